// File: doc/BRIEF.md
# Serial Peripheral Handshake Controller

This block sits between a serial transmitter and an external printer-style peripheral and owns the control lines between them. It drives three outbound status lines: a receive gate, a data-set-ready indication and a carrier indication. It samples three inbound lines: an output-enable handshake, an equipment-ready line and a paper-out line. From the output-enable line it decides when the host may hand over the next byte. When output is stopped, a bounded number of bytes may still leave after the stop edge.

The host offers a byte by holding `tx_req`. The block answers with a one-cycle `tx_ack` and then holds `tx_busy` for the fixed time it takes to shift one byte out. Serialisation, parity and baud generation belong to other blocks. While a byte is being output, the block watches the equipment-ready and paper-out lines. If either shows a violation, it raises a sticky error that refuses further requests until software clears it. Three static switches set the block's behaviour: the carrier-indication mode, whether the ready check is active, and the polarity of paper-out.

Top module: `periph_handshake_ctrl`

## Requirements
- R1: `dsr` is 0 while `rst_n` is low and is 1 from the first clock edge after reset is released.
- R2: With `sw_cd_always`=1, `cd` equals `dsr`. With `sw_cd_always`=0, `cd` equals `tx_busy`.
- R3: `rx_gate` is 0 in reset. It takes the value of `host_rx_en` one clock later.
- R4: A request is accepted when `tx_req`=1, `tx_busy`=0, `err`=0 and sending is permitted. Acceptance shows as `tx_ack`=1 for exactly one cycle, the cycle after the request is seen. In that same cycle `tx_busy` rises, and it stays 1 for BYTE_CYCLES (default 8) cycles.
- R5: While the synchronised `pr_oe` is 0, at most BURST_LIMIT (default 2) requests are accepted after its falling edge. Further requests wait, and are accepted once `pr_oe` is back at 1.
- R6: After reset, the allowance is already used up. No request is accepted until `pr_oe` has been seen at 1.
- R7: With `sw_rdy_check`=1, a 0 on `pr_equip_rdy` while `tx_busy`=1 sets `err`.
- R8: With `sw_rdy_check`=0, `pr_equip_rdy` has no effect on `err`.
- R9: `pr_paper_out` equal to `sw_po_active_high` while `tx_busy`=1 sets `err`. The opposite level does not set it.
- R10: `err` is sticky, and requests are refused while it is 1. A one-cycle `err_clr` clears it. If a violation and `err_clr` fall in the same cycle, the violation wins.
- R11: All three inbound lines pass through SYNC_STAGES (at least 2) flops. A ready or paper-out violation present only while `tx_busy`=0 does not set `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_cd_always | input | 1 | Carrier mode: 1 = always high, 0 = high while outputting |
| sw_rdy_check | input | 1 | Enables the equipment-ready check |
| sw_po_active_high | input | 1 | Paper-out level that counts as an error |
| host_rx_en | input | 1 | Host request to accept data from the peripheral |
| tx_req | input | 1 | Host offers a byte for output |
| err_clr | input | 1 | Clears the sticky error |
| pr_oe | input | 1 | Peripheral output-enable handshake |
| pr_equip_rdy | input | 1 | Peripheral equipment-ready |
| pr_paper_out | input | 1 | Peripheral paper-out |
| rx_gate | output | 1 | Receive gate to the peripheral |
| dsr | output | 1 | Data-set-ready to the peripheral |
| cd | output | 1 | Carrier indication to the peripheral |
| tx_ack | output | 1 | One-cycle acceptance of a request |
| tx_busy | output | 1 | A byte is being output |
| err | output | 1 | Sticky handshake error |

## Verification
Two events can fall in the same cycle. One is the software clear of the error flag. The other is a fresh handshake violation seen during an output byte. The bench holds `pr_equip_rdy` low across a whole byte and pulses `err_clr` for one cycle while `tx_busy` is high, then expects `err` to remain 1. Once the byte has ended, it issues a second clear and expects `err` to fall.

// File: rtl/phc_pkg.sv
package phc_pkg;
   // width needed to hold values 0..n
   function automatic int cnt_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/phc_sync.sv
module phc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < 2) $error("phc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/phc_burst_gate.sv
module phc_burst_gate #(
   parameter int LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_s,
   input  logic take,
   output logic allow
);
   import phc_pkg::*;
   localparam int CW = cnt_width(LIMIT);
   localparam logic [CW-1:0] FULL = CW'(LIMIT);

   initial begin
      if (LIMIT < 1) $error("phc_burst_gate: LIMIT must be at least 1");
   end

   logic [CW-1:0] sent_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     sent_q <= FULL;   // R6: start exhausted
      else if (oe_s)                  sent_q <= '0;
      else if (take && sent_q != FULL) sent_q <= sent_q + 1'b1;

   assign allow = oe_s || (sent_q != FULL);

   // R5: once the allowance is spent under a stop, nothing more is taken
   assert_no_take_when_spent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_s && sent_q == FULL) |-> !take);
   assert_sent_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sent_q <= FULL);
endmodule

// File: rtl/phc_err_mon.sv
module phc_err_mon (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic rdy_check_en,
   input  logic po_err_level,
   input  logic rdy_s,
   input  logic po_s,
   input  logic clr,
   output logic err
);
   logic viol;
   logic err_q;

   // R7/R8/R9/R11: violations count only while a byte is going out
   assign viol = busy && ((rdy_check_en && !rdy_s) || (po_s == po_err_level));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    err_q <= 1'b0;
      else if (viol) err_q <= 1'b1;   // R10: set beats clear
      else if (clr)  err_q <= 1'b0;

   assign err = err_q;

   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !clr) |=> err_q);
   assert_err_needs_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_q && !busy) |=> !err_q);
endmodule

// File: rtl/periph_handshake_ctrl.sv
module periph_handshake_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter int BURST_LIMIT = 2,
   parameter int BYTE_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_cd_always,
   input  logic sw_rdy_check,
   input  logic sw_po_active_high,
   input  logic host_rx_en,
   input  logic tx_req,
   input  logic err_clr,
   input  logic pr_oe,
   input  logic pr_equip_rdy,
   input  logic pr_paper_out,
   output logic rx_gate,
   output logic dsr,
   output logic cd,
   output logic tx_ack,
   output logic tx_busy,
   output logic err
);
   import phc_pkg::*;
   localparam int TW = cnt_width(BYTE_CYCLES);
   localparam int NIN = 3;

   initial begin
      if (BYTE_CYCLES < 1) $error("periph_handshake_ctrl: BYTE_CYCLES must be at least 1");
   end

   // inbound synchronisers (R11)
   logic [NIN-1:0] raw_in, syn_in;
   assign raw_in = {pr_paper_out, pr_equip_rdy, pr_oe};

   genvar gi;
   generate
      for (gi = 0; gi < NIN; gi++) begin : g_in
         phc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw_in[gi]), .q(syn_in[gi]));
      end
   endgenerate

   logic oe_s, rdy_s, po_s;
   assign oe_s  = syn_in[0];
   assign rdy_s = syn_in[1];
   assign po_s  = syn_in[2];

   // outbound status (R1, R3)
   logic dsr_q, rxg_q;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         dsr_q <= 1'b0;
         rxg_q <= 1'b0;
      end else begin
         dsr_q <= 1'b1;
         rxg_q <= host_rx_en;
      end

   // byte timing and acceptance (R4)
   logic          allow, accept, busy_q, ack_q, err_w;
   logic [TW-1:0] tmr_q;

   assign accept = tx_req && !busy_q && !err_w && allow;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         busy_q <= 1'b0;
         tmr_q  <= '0;
         ack_q  <= 1'b0;
      end else begin
         ack_q <= accept;
         if (accept) begin
            busy_q <= 1'b1;
            tmr_q  <= TW'(BYTE_CYCLES - 1);
         end else if (busy_q) begin
            if (tmr_q == '0) busy_q <= 1'b0;
            else             tmr_q  <= tmr_q - 1'b1;
         end
      end

   phc_burst_gate #(.LIMIT(BURST_LIMIT)) u_gate (
      .clk(clk), .rst_n(rst_n), .oe_s(oe_s), .take(accept), .allow(allow));

   phc_err_mon u_err (
      .clk(clk), .rst_n(rst_n), .busy(busy_q), .rdy_check_en(sw_rdy_check),
      .po_err_level(sw_po_active_high), .rdy_s(rdy_s), .po_s(po_s),
      .clr(err_clr), .err(err_w));

   assign rx_gate = rxg_q;
   assign dsr     = dsr_q;
   assign cd      = sw_cd_always ? dsr_q : busy_q;   // R2
   assign tx_ack  = ack_q;
   assign tx_busy = busy_q;
   assign err     = err_w;

   assert_dsr_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> dsr_q);
   assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |=> !ack_q);
   assert_ack_with_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> busy_q);
   assert_no_ack_after_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_w |=> !ack_q);
endmodule

// File: tb/test_periph_handshake_ctrl.sv
module test_periph_handshake_ctrl;
   logic clk = 1'b0, rst_n = 1'b0;
   logic sw_cd_always = 1'b1, sw_rdy_check = 1'b1, sw_po_active_high = 1'b1;
   logic host_rx_en = 1'b0, tx_req = 1'b0, err_clr = 1'b0;
   logic pr_oe = 1'b0, pr_equip_rdy = 1'b1, pr_paper_out = 1'b0;
   logic rx_gate, dsr, cd, tx_ack, tx_busy, err;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   periph_handshake_ctrl i_periph_handshake_ctrl (.*);

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // offer a byte; report whether it was accepted within 'wait_n' cycles
   task automatic send(input int wait_n, output bit got);
      got = 1'b0;
      tx_req = 1'b1;
      for (int i = 0; i < wait_n; i++) begin
         @(negedge clk);
         if (tx_ack) begin got = 1'b1; break; end
      end
      tx_req = 1'b0;
      if (got) while (tx_busy) @(negedge clk);
   endtask

   task automatic t_reset;
      bit got;
      chk("R1 dsr in reset", dsr, 1'b0);
      chk("R3 rx_gate in reset", rx_gate, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      cyc(1);
      chk("R1 dsr after reset", dsr, 1'b1);
      chk("R2 cd always mode", cd, 1'b1);
      send(12, got);
      chk("R6 no accept before oe seen high", got, 1'b0);
      pr_oe = 1'b1; cyc(4);
      send(12, got);
      chk("R6 accept once oe high", got, 1'b1);
   endtask

   task automatic t_rx_gate;
      host_rx_en = 1'b1; cyc(1);
      chk("R3 rx_gate follows high", rx_gate, 1'b1);
      host_rx_en = 1'b0; cyc(1);
      chk("R3 rx_gate follows low", rx_gate, 1'b0);
   endtask

   task automatic t_basic;
      int busy_n = 0, ack_n = 0;
      sw_cd_always = 1'b0; cyc(1);
      chk("R2 cd low when idle", cd, 1'b0);
      tx_req = 1'b1;
      @(negedge clk);
      tx_req = 1'b0;
      chk("R4 ack next cycle", tx_ack, 1'b1);
      chk("R2 cd tracks busy", cd, 1'b1);
      while (tx_busy) begin
         busy_n++;
         if (tx_ack) ack_n++;
         @(negedge clk);
      end
      chk("R4 busy lasts 8 cycles", busy_n == 8, 1'b1);
      chk("R4 single ack pulse", ack_n == 1, 1'b1);
      sw_cd_always = 1'b1;
   endtask

   task automatic t_burst;
      bit g1, g2, g3;
      pr_oe = 1'b0; cyc(4);
      send(12, g1); send(12, g2); send(20, g3);
      chk("R5 first byte after stop", g1, 1'b1);
      chk("R5 second byte after stop", g2, 1'b1);
      chk("R5 third byte held", g3, 1'b0);
      pr_oe = 1'b1; cyc(4);
      send(12, g3);
      chk("R5 resume after oe high", g3, 1'b1);
   endtask

   task automatic t_ready;
      bit got;
      pr_equip_rdy = 1'b0; cyc(12);
      chk("R11 idle violation ignored", err, 1'b0);
      send(12, got);
      chk("R7 ready low sets err", err, 1'b1);
      send(12, got);
      chk("R10 request refused under err", got, 1'b0);
      pr_equip_rdy = 1'b1; cyc(4);
      err_clr = 1'b1; cyc(1); err_clr = 1'b0;
      chk("R10 clear drops err", err, 1'b0);
      sw_rdy_check = 1'b0; pr_equip_rdy = 1'b0; cyc(4);
      send(12, got);
      chk("R8 ready ignored when check off", err, 1'b0);
      pr_equip_rdy = 1'b1; sw_rdy_check = 1'b1; cyc(4);
   endtask

   task automatic t_paper;
      bit got;
      pr_paper_out = 1'b1; cyc(4);
      send(12, got);
      chk("R9 paper-out high level errors", err, 1'b1);
      err_clr = 1'b1; cyc(1); err_clr = 1'b0;
      sw_po_active_high = 1'b0; cyc(1);
      send(12, got);
      chk("R9 inactive level accepted", got, 1'b1);
      chk("R9 inactive level no err", err, 1'b0);
      pr_paper_out = 1'b0; cyc(4);
      send(12, got);
      chk("R9 paper-out low level errors", err, 1'b1);
      err_clr = 1'b1; cyc(1); err_clr = 1'b0;
      sw_po_active_high = 1'b1; cyc(4);
   endtask

   task automatic t_clear_vs_violation;
      pr_equip_rdy = 1'b0; cyc(4);
      tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
      cyc(3);
      err_clr = 1'b1; cyc(1); err_clr = 1'b0;
      chk("R10 violation beats clear", err, 1'b1);
      while (tx_busy) @(negedge clk);
      pr_equip_rdy = 1'b1; cyc(4);
      err_clr = 1'b1; cyc(1); err_clr = 1'b0;
      chk("R10 clear after byte", err, 1'b0);
   endtask

   initial begin
      cyc(2);
      t_reset;
      t_rx_gate;
      t_basic;
      t_burst;
      t_ready;
      t_paper;
      t_clear_vs_violation;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule